// File: doc/BRIEF.md
# FIFO Threshold Offset Configuration Unit

This unit supplies the two threshold offsets that a FIFO's almost-empty and almost-full flag logic compares against. While the synchronous full reset is held, a 3-bit select input and a parity option are captured. The select either picks a fixed power-of-two offset, which then serves as both thresholds, or chooses one of two user loading methods. The unit then fills the two offset registers from that source and raises a completion flag.

In the parallel method, the first two enabled writes on the wide write-side data port supply the offsets. When the parity option is on, data bit 8 is treated as a parity position and squeezed out of the offset. In the serial method, the offsets arrive one bit per enabled clock on a dedicated serial input. A partial reset, meant for flushing the FIFO, keeps every setting and every captured offset, and restarts an unfinished load. The FIFO storage and flag comparators are outside this unit.

Top module: `fifo_ofs_cfg`

## Requirements
- R1: When full_rst is sampled high, mode_sel selects a preset that drives both ae_ofs and af_ofs from the next cycle, with load_done high: code 0 gives 8, 1 gives 16, 2 gives 64, 3 gives 256, 4 gives 1024 and 7 gives 64.
- R2: Code 5 selects the serial method and code 6 the parallel method; after such a full reset both offsets read 0 and load_done is low.
- R3: In the parallel method, the first clock edge with wr_en high loads ae_ofs and the second loads af_ofs and sets load_done; each change is visible after its edge.
- R4: With parity_sel low at full reset, a parallel load takes wr_data[OFS_W-1:0] as the offset.
- R5: With parity_sel high at full reset, a parallel load ignores wr_data[8]: the offset is wr_data[7:0] in bits 7:0 and wr_data[OFS_W:9] in bits OFS_W-1:8.
- R6: In the serial method, ser_din is taken on each edge with ser_en high, least significant bit first: the first OFS_W bits form ae_ofs, the next OFS_W bits form af_ofs, and load_done rises after bit 2*OFS_W.
- R7: Once load_done is high, wr_en and ser_en leave the offsets unchanged; during a load, the strobe of the unselected method is ignored, and in preset mode both strobes are ignored.
- R8: part_rst changes no offset, no load_done and no setting; the strobes are ignored in that cycle, and an unfinished load restarts with ae_ofs next.
- R9: mode_sel and parity_sel have no effect unless full_rst is high.
- R10: load_done, once high, stays high until the next full reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| full_rst | input | 1 | Synchronous full reset, active high; samples the settings |
| part_rst | input | 1 | Synchronous partial reset, active high |
| mode_sel | input | 3 | Offset source select, sampled during full reset |
| parity_sel | input | 1 | Parity option, sampled during full reset |
| wr_en | input | 1 | Write-side enable for parallel loading |
| wr_data | input | DATA_W (36) | Write-side data |
| ser_en | input | 1 | Serial shift enable |
| ser_din | input | 1 | Serial offset data |
| ae_ofs | output | OFS_W (16) | Almost-empty offset |
| af_ofs | output | OFS_W (16) | Almost-full offset |
| load_done | output | 1 | Both offsets are in place |

## Verification
The bench builds the unit with its defaults, DATA_W = 36 and OFS_W = 16. With these values every preset up to 1024 fits, and the squeezed parallel field reaches past bit 8 into the upper data bits, so a word whose bit 8 differs from bit 9 tells the two parity settings apart. A full serial load is 32 shifts, so both serial halves and the done edge are short enough to step through one bit at a time. The partial-reset cases are also reachable within a few cycles.

// File: rtl/ofs_cfg_pkg.sv
`timescale 1ns/1ps
package ofs_cfg_pkg;

  typedef enum logic [1:0] {
    SRC_PRESET   = 2'd0,
    SRC_SERIAL   = 2'd1,
    SRC_PARALLEL = 2'd2
  } src_e;

  localparam logic [2:0] CODE_SERIAL   = 3'd5;
  localparam logic [2:0] CODE_PARALLEL = 3'd6;

  // R1 R2: source decode of the select code
  function automatic src_e decode_src(input logic [2:0] code);
    case (code)
      CODE_SERIAL:   return SRC_SERIAL;
      CODE_PARALLEL: return SRC_PARALLEL;
      default:       return SRC_PRESET;
    endcase
  endfunction

  // R1: exponent of the power-of-two preset; code 7 falls back to 64
  function automatic int unsigned preset_log2(input logic [2:0] code);
    case (code)
      3'd0:    return 3;
      3'd1:    return 4;
      3'd2:    return 6;
      3'd3:    return 8;
      3'd4:    return 10;
      default: return 6;
    endcase
  endfunction

endpackage

// File: rtl/ofs_mode_latch.sv
`timescale 1ns/1ps
module ofs_mode_latch
  import ofs_cfg_pkg::*;
#(
  parameter int OFS_W = 16
) (
  input  logic             clk,
  input  logic             full_rst,
  input  logic [2:0]       mode_sel,
  input  logic             parity_sel,
  output src_e             src,
  output logic             parity_on,
  output logic             rst_is_preset,
  output logic [OFS_W-1:0] rst_preset
);

  // R9: settings are captured only while full reset is held
  always_ff @(posedge clk) begin
    if (full_rst) begin
      src       <= decode_src(mode_sel);
      parity_on <= parity_sel;
    end
  end

  always_comb begin
    rst_is_preset = (decode_src(mode_sel) == SRC_PRESET);
    rst_preset    = OFS_W'(1) << preset_log2(mode_sel);
  end

endmodule

// File: rtl/ofs_par_seq.sv
`timescale 1ns/1ps
module ofs_par_seq #(
  parameter int DATA_W = 36,
  parameter int OFS_W  = 16
) (
  input  logic              clk,
  input  logic              full_rst,
  input  logic              part_rst,
  input  logic              active,
  input  logic              parity_on,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              ae_we,
  output logic              af_we,
  output logic [OFS_W-1:0]  par_val
);

  localparam int PAR_BIT = 8;

  // R4 R5: offset field, with the parity position squeezed out when enabled
  function automatic logic [OFS_W-1:0] pick_field(input logic [DATA_W-1:0] d,
                                                  input logic par);
    logic [OFS_W-1:0] r;
    for (int i = 0; i < OFS_W; i++) begin
      r[i] = (par && i >= PAR_BIT) ? d[i+1] : d[i];
    end
    return r;
  endfunction

  logic second_q;
  logic take;

  always_comb begin
    take    = active && wr_en && !part_rst && !full_rst;
    ae_we   = take && !second_q;
    af_we   = take && second_q;
    par_val = pick_field(wr_data, parity_on);
  end

  // R3 R8: first write goes to almost-empty, partial reset restarts
  always_ff @(posedge clk) begin
    if (full_rst || part_rst) second_q <= 1'b0;
    else if (ae_we)           second_q <= 1'b1;
  end

endmodule

// File: rtl/ofs_ser_seq.sv
`timescale 1ns/1ps
module ofs_ser_seq #(
  parameter int OFS_W = 16
) (
  input  logic clk,
  input  logic full_rst,
  input  logic part_rst,
  input  logic active,
  input  logic ser_en,
  output logic ae_sh,
  output logic af_sh,
  output logic ser_last
);

  localparam int TOTAL = 2 * OFS_W;
  localparam int CNT_W = $clog2(TOTAL);

  logic [CNT_W-1:0] cnt_q;
  logic             shift;

  // R6: first OFS_W bits feed almost-empty, the rest almost-full
  always_comb begin
    shift    = active && ser_en && !part_rst && !full_rst;
    ae_sh    = shift && (cnt_q <  CNT_W'(OFS_W));
    af_sh    = shift && (cnt_q >= CNT_W'(OFS_W));
    ser_last = af_sh && (cnt_q == CNT_W'(TOTAL - 1));
  end

  // R8: partial reset restarts the bit count
  always_ff @(posedge clk) begin
    if (full_rst || part_rst) cnt_q <= '0;
    else if (shift)           cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/fifo_ofs_cfg.sv
`timescale 1ns/1ps
module fifo_ofs_cfg
  import ofs_cfg_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int OFS_W  = 16
) (
  input  logic              clk,
  input  logic              full_rst,
  input  logic              part_rst,
  input  logic [2:0]        mode_sel,
  input  logic              parity_sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ser_en,
  input  logic              ser_din,
  output logic [OFS_W-1:0]  ae_ofs,
  output logic [OFS_W-1:0]  af_ofs,
  output logic              load_done
);

  src_e             src;
  logic             parity_on;
  logic             rst_is_preset;
  logic [OFS_W-1:0] rst_preset;

  logic             par_active;
  logic             ser_active;
  logic             ae_we;
  logic             af_we;
  logic [OFS_W-1:0] par_val;
  logic             ser_ae_sh;
  logic             ser_af_sh;
  logic             ser_last;

  logic [OFS_W-1:0] ae_q;
  logic [OFS_W-1:0] af_q;
  logic             done_q;

  ofs_mode_latch #(.OFS_W(OFS_W)) u_mode (
    .clk           (clk),
    .full_rst      (full_rst),
    .mode_sel      (mode_sel),
    .parity_sel    (parity_sel),
    .src           (src),
    .parity_on     (parity_on),
    .rst_is_preset (rst_is_preset),
    .rst_preset    (rst_preset)
  );

  // R7: a loader runs only for its own method and only until done
  always_comb begin
    par_active = (src == SRC_PARALLEL) && !done_q;
    ser_active = (src == SRC_SERIAL)   && !done_q;
  end

  ofs_par_seq #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_par (
    .clk       (clk),
    .full_rst  (full_rst),
    .part_rst  (part_rst),
    .active    (par_active),
    .parity_on (parity_on),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .ae_we     (ae_we),
    .af_we     (af_we),
    .par_val   (par_val)
  );

  ofs_ser_seq #(.OFS_W(OFS_W)) u_ser (
    .clk      (clk),
    .full_rst (full_rst),
    .part_rst (part_rst),
    .active   (ser_active),
    .ser_en   (ser_en),
    .ae_sh    (ser_ae_sh),
    .af_sh    (ser_af_sh),
    .ser_last (ser_last)
  );

  // R1 R2 R10: offset registers and completion flag
  always_ff @(posedge clk) begin
    if (full_rst) begin
      ae_q   <= rst_is_preset ? rst_preset : '0;
      af_q   <= rst_is_preset ? rst_preset : '0;
      done_q <= rst_is_preset;
    end else begin
      if (ae_we)     ae_q <= par_val;
      if (af_we)     af_q <= par_val;
      if (ser_ae_sh) ae_q <= {ser_din, ae_q[OFS_W-1:1]};
      if (ser_af_sh) af_q <= {ser_din, af_q[OFS_W-1:1]};
      if (af_we || ser_last) done_q <= 1'b1;
    end
  end

  assign ae_ofs    = ae_q;
  assign af_ofs    = af_q;
  assign load_done = done_q;

endmodule

// File: rtl/ofs_cfg_chk.sv
`timescale 1ns/1ps
module ofs_cfg_chk #(
  parameter int OFS_W = 16
) (
  input logic             clk,
  input logic             full_rst,
  input logic             part_rst,
  input logic [2:0]       mode_sel,
  input logic             load_done,
  input logic [OFS_W-1:0] ae_ofs,
  input logic [OFS_W-1:0] af_ofs,
  input logic             ae_we,
  input logic             af_we,
  input logic             ser_ae_sh,
  input logic             ser_af_sh,
  input logic             ser_last
);

  assert_preset_pair_R1: assert property (@(posedge clk) disable iff (full_rst)
    ($past(full_rst) && $past(mode_sel) != 3'd5 && $past(mode_sel) != 3'd6)
      |-> (load_done && ae_ofs == af_ofs && $countones(ae_ofs) == 1));

  assert_user_clear_R2: assert property (@(posedge clk) disable iff (full_rst)
    ($past(full_rst) && ($past(mode_sel) == 3'd5 || $past(mode_sel) == 3'd6))
      |-> (!load_done && ae_ofs == '0 && af_ofs == '0));

  assert_one_event_R3: assert property (@(posedge clk) disable iff (full_rst)
    $onehot0({ae_we, af_we, ser_ae_sh, ser_af_sh}));

  assert_par_finish_R3: assert property (@(posedge clk) disable iff (full_rst)
    af_we |=> load_done);

  assert_ser_finish_R6: assert property (@(posedge clk) disable iff (full_rst)
    ser_last |=> load_done);

  assert_frozen_when_done_R7: assert property (@(posedge clk) disable iff (full_rst)
    load_done |=> ($stable(ae_ofs) && $stable(af_ofs)));

  assert_partial_keeps_R8: assert property (@(posedge clk) disable iff (full_rst)
    part_rst |=> ($stable(ae_ofs) && $stable(af_ofs) && $stable(load_done)));

  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (full_rst)
    load_done |=> load_done);

  assert_done_cause_R10: assert property (@(posedge clk) disable iff (full_rst)
    $rose(load_done) |-> $past(af_we || ser_last || full_rst));

endmodule

bind fifo_ofs_cfg ofs_cfg_chk #(.OFS_W(OFS_W)) u_chk (
  .clk       (clk),
  .full_rst  (full_rst),
  .part_rst  (part_rst),
  .mode_sel  (mode_sel),
  .load_done (load_done),
  .ae_ofs    (ae_ofs),
  .af_ofs    (af_ofs),
  .ae_we     (ae_we),
  .af_we     (af_we),
  .ser_ae_sh (ser_ae_sh),
  .ser_af_sh (ser_af_sh),
  .ser_last  (ser_last)
);

// File: tb/sim_fifo_ofs_cfg.sv
`timescale 1ns/1ps
module sim_fifo_ofs_cfg;

  localparam int DATA_W = 36;
  localparam int OFS_W  = 16;

  logic              clk = 1'b0;
  logic              full_rst = 1'b1;
  logic              part_rst = 1'b0;
  logic [2:0]        mode_sel = 3'd0;
  logic              parity_sel = 1'b0;
  logic              wr_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              ser_en = 1'b0;
  logic              ser_din = 1'b0;
  logic [OFS_W-1:0]  ae_ofs;
  logic [OFS_W-1:0]  af_ofs;
  logic              load_done;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fifo_ofs_cfg #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u0 (
    .clk(clk), .full_rst(full_rst), .part_rst(part_rst), .mode_sel(mode_sel),
    .parity_sel(parity_sel), .wr_en(wr_en), .wr_data(wr_data), .ser_en(ser_en),
    .ser_din(ser_din), .ae_ofs(ae_ofs), .af_ofs(af_ofs), .load_done(load_done)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [OFS_W-1:0] exp_preset(input int code);
    int tbl[8] = '{8, 16, 64, 256, 1024, 0, 0, 64};
    return OFS_W'(tbl[code]);
  endfunction

  // squeeze bit 8 out by arithmetic: keep low byte, move the rest down one place
  function automatic logic [OFS_W-1:0] exp_field(input logic [DATA_W-1:0] d, input bit par);
    logic [DATA_W-1:0] v;
    v = par ? (((d >> 9) << 8) | (d & 36'hFF)) : d;
    return v[OFS_W-1:0];
  endfunction

  task automatic do_full_reset(input logic [2:0] code, input logic par);
    @(negedge clk);
    full_rst = 1'b1; mode_sel = code; parity_sel = par;
    @(negedge clk);
    full_rst = 1'b0;
  endtask

  task automatic par_write(input logic [DATA_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ser_word(input logic [OFS_W-1:0] w, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      ser_en = 1'b1; ser_din = w[i];
    end
    @(negedge clk);
    ser_en = 1'b0;
  endtask

  task automatic part_pulse(input logic [DATA_W-1:0] d);
    @(negedge clk);
    part_rst = 1'b1; wr_en = 1'b1; wr_data = d; ser_en = 1'b1; ser_din = 1'b1;
    @(negedge clk);
    part_rst = 1'b0; wr_en = 1'b0; ser_en = 1'b0;
  endtask

  task automatic t_presets();
    int codes[6] = '{0, 1, 2, 3, 4, 7};
    for (int k = 0; k < 6; k++) begin
      do_full_reset(3'(codes[k]), 1'b0);
      chk($sformatf("R1 ae preset code %0d", codes[k]), ae_ofs, exp_preset(codes[k]));
      chk($sformatf("R1 af preset code %0d", codes[k]), af_ofs, exp_preset(codes[k]));
      chk($sformatf("R1 done preset code %0d", codes[k]), load_done, 1);
    end
    repeat (3) @(negedge clk);
    chk("R10 done held in preset mode", load_done, 1);
  endtask

  task automatic t_user_codes();
    do_full_reset(3'd5, 1'b0);
    chk("R2 serial ae cleared", ae_ofs, 0);
    chk("R2 serial done low", load_done, 0);
    do_full_reset(3'd6, 1'b0);
    chk("R2 parallel af cleared", af_ofs, 0);
    chk("R2 parallel done low", load_done, 0);
  endtask

  task automatic t_parallel(input bit par);
    logic [DATA_W-1:0] d0, d1;
    d0 = 36'h9_0C3A_5355;
    d1 = 36'h6_A7E1_02F0;
    do_full_reset(3'd6, par);
    par_write(d0);
    chk(par ? "R5 ae squeezed" : "R4 ae plain", ae_ofs, exp_field(d0, par));
    chk("R3 done low after first write", load_done, 0);
    par_write(d1);
    chk(par ? "R5 af squeezed" : "R4 af plain", af_ofs, exp_field(d1, par));
    chk("R3 ae kept after second write", ae_ofs, exp_field(d0, par));
    chk("R3 done after second write", load_done, 1);
    par_write(36'hF_FFFF_FFFF);
    chk("R7 write after done ignored", ae_ofs, exp_field(d0, par));
    chk("R7 write after done af", af_ofs, exp_field(d1, par));
  endtask

  task automatic t_serial();
    logic [OFS_W-1:0] va, vf;
    va = 16'hA5C3;
    vf = 16'h0F71;
    do_full_reset(3'd5, 1'b1);
    ser_word(va, OFS_W);
    chk("R6 ae after first half", ae_ofs, va);
    chk("R6 done low mid load", load_done, 0);
    ser_word(vf, OFS_W - 1);
    chk("R6 done low before last bit", load_done, 0);
    ser_word({1'b0, vf[OFS_W-1:1]} >> (OFS_W - 2), 1);
    chk("R6 af after second half", af_ofs, vf);
    chk("R6 done after last bit", load_done, 1);
    ser_word(16'h1234, OFS_W);
    chk("R7 serial after done ignored", ae_ofs, va);
    par_write(36'h0_0000_FFFF);
    chk("R7 write after serial done ignored", af_ofs, vf);
  endtask

  task automatic t_cross_method();
    do_full_reset(3'd5, 1'b0);
    par_write(36'h0_0000_BEEF);
    chk("R7 write ignored in serial mode", ae_ofs, 0);
    chk("R7 done low in serial mode", load_done, 0);
    do_full_reset(3'd6, 1'b0);
    ser_word(16'hFFFF, 4);
    chk("R7 serial ignored in parallel mode", ae_ofs, 0);
    do_full_reset(3'd3, 1'b0);
    par_write(36'h0_0000_0011);
    ser_word(16'hFFFF, 4);
    chk("R7 strobes ignored in preset mode", ae_ofs, 256);
  endtask

  task automatic t_partial();
    do_full_reset(3'd6, 1'b0);
    par_write(36'h0_0000_1111);
    part_pulse(36'h0_0000_9999);
    chk("R8 ae kept by partial reset", ae_ofs, 16'h1111);
    chk("R8 af untouched by partial reset", af_ofs, 0);
    chk("R8 done low after partial reset", load_done, 0);
    par_write(36'h0_0000_2222);
    chk("R8 restart writes ae", ae_ofs, 16'h2222);
    par_write(36'h0_0000_3333);
    chk("R8 af after restart", af_ofs, 16'h3333);
    part_pulse(36'h0_0000_7777);
    chk("R8 done kept by partial reset", load_done, 1);
    chk("R8 af kept after done", af_ofs, 16'h3333);
    do_full_reset(3'd5, 1'b0);
    ser_word(16'h001F, 5);
    part_pulse('0);
    ser_word(16'h4C2B, OFS_W);
    ser_word(16'h91E6, OFS_W);
    chk("R8 serial restart ae", ae_ofs, 16'h4C2B);
    chk("R8 serial restart af", af_ofs, 16'h91E6);
  endtask

  task automatic t_settings_locked();
    logic [DATA_W-1:0] d;
    d = 36'h0_0000_0355;
    do_full_reset(3'd6, 1'b1);
    @(negedge clk);
    mode_sel = 3'd0; parity_sel = 1'b0;
    par_write(d);
    chk("R9 method and parity kept", ae_ofs, exp_field(d, 1'b1));
    chk("R9 no preset from late select", load_done, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    full_rst = 1'b0;
    chk("R1 reset state done", load_done, 1);
    chk("R1 reset state ae", ae_ofs, 8);
    t_presets();
    t_user_codes();
    t_parallel(1'b0);
    t_parallel(1'b1);
    t_serial();
    t_cross_method();
    t_partial();
    t_settings_locked();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule